// File: doc/BRIEF.md
# Debug Breakpoint Match Unit

This unit watches the processor's buses and raises a request to enter debug mode when a programmed address or register write appears. It holds six 16-bit breakpoint registers, a compare-mask register, a compare-data register and a two-bit control word. All of them are loaded only through a host-side debug port. Breakpoints 0 to 3 compare against the instruction fetch address.

Breakpoints 4 and 5 have two modes. In address mode they compare against the data-memory address. In register mode they decode a destination module and register index, and they check the written value under a mask.

A match raises a one-cycle break request and moves the status output from background (`2'b00`) to debug-idle (`2'b01`). Further matches are then ignored until the host resumes. A match on an instruction that opens a prefix is held back until the prefixed operation completes. The host can also force entry directly.

Top module: `dbg_brk_unit`

## Requirements
- R1: After reset, and in the cycle after `tlr` is high, all six breakpoint registers read `16'hFFFF`. After reset, `brk_req` is 0 and `dbg_status` is `2'b00`. Mask, data and control words reset to 0.
- R2: The host port writes on `host_wr_en`. `host_rdata` returns the word selected by `host_addr`. The address map is: 0..5 for breakpoints 0..5, 6 for the mask, 7 for the compare data, and 8 for control. In the control word, bit 0 is the debug enable and bit 1 is the register mode.
- R3: While the debug enable is 0, no breakpoint match produces a break.
- R4: Breakpoints 0..3 match only when `fetch_valid` is 1 and all 16 bits of `fetch_addr` are equal to the breakpoint value.
- R5: With register mode 0, breakpoints 4 and 5 match `dmem_addr` when `dmem_valid` is 1, and destination writes do not trigger them.
- R6: With register mode 1, breakpoints 4 and 5 match a destination write when bits [3:0] equal `dst_module` and bits [8:4] equal `dst_index`. Bits [15:9] are ignored, and data-memory addresses do not trigger them.
- R7: A register-mode match also requires `dst_wdata` to equal the compare data on every bit where the mask is 1. A zero mask makes the value test always true.
- R8: A match in a cycle with `insn_prefix` high does not break at once. The break is issued after the first later cycle that has `insn_done` high and `insn_prefix` low.
- R9: A break drives `brk_req` high for exactly one cycle, one clock after the match cycle, and sets `dbg_status` to `2'b01` at the same time.
- R10: While in debug-idle, matches are ignored. `host_resume` returns `dbg_status` to `2'b00` on the next clock.
- R11: `host_break_cmd` in background forces a break, whatever the debug enable and the breakpoint values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tlr | input | 1 | Test-logic-reset indication; reloads the breakpoints with all ones |
| host_wr_en | input | 1 | Host write strobe |
| host_addr | input | 4 | Host word select |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_addr` |
| host_break_cmd | input | 1 | Host command to enter debug mode |
| host_resume | input | 1 | Host command to return to background |
| fetch_valid | input | 1 | Instruction fetch address is valid |
| fetch_addr | input | 16 | Instruction fetch address |
| dmem_valid | input | 1 | Data-memory access is valid |
| dmem_addr | input | 16 | Data-memory address |
| dst_valid | input | 1 | Executed instruction writes a destination register |
| dst_module | input | 4 | Destination module specifier |
| dst_index | input | 5 | Destination register index |
| dst_wdata | input | 16 | Value written to the destination |
| insn_prefix | input | 1 | Current instruction activates a prefix |
| insn_done | input | 1 | Current operation completes |
| brk_req | output | 1 | One-cycle break request |
| dbg_status | output | 2 | 00 background, 01 debug-idle |

## Verification
The hardest case to reach is the deferred break. It needs a match that lands on a prefix cycle, then at least one cycle with neither flag set, then the completion cycle. The bench drives that exact three-cycle pattern and expects silence on the first two cycles and the break only after the third. Register-mode value masking is reached by first programming mode, mask and data through the host port. The bench then presents one write that differs only inside the masked field and one that differs only outside it.

// File: rtl/dbg_bp_pkg.sv
package dbg_bp_pkg;
    parameter int unsigned BP_W    = 16;
    parameter int unsigned NUM_BP  = 6;
    parameter int unsigned NUM_IBP = 4;
    parameter int unsigned MOD_W   = 4;
    parameter int unsigned IDX_W   = 5;
    parameter int unsigned HADDR_W = 4;

    localparam int unsigned HA_MASK = NUM_BP;
    localparam int unsigned HA_DATA = NUM_BP + 1;
    localparam int unsigned HA_CTRL = NUM_BP + 2;

    typedef enum logic [1:0] {
        ST_BACKGROUND = 2'b00,
        ST_DEBUG_IDLE = 2'b01
    } dbg_state_e;

    typedef struct packed {
        logic [NUM_BP-1:0][BP_W-1:0] bp;
        logic [BP_W-1:0]             mask;
        logic [BP_W-1:0]             cmp;
        logic                        en;
        logic                        mode;
    } hregs_t;

    typedef struct packed {
        logic       brk;
        dbg_state_e st;
        logic       pend;
    } seq_t;
endpackage

// File: rtl/dbg_bp_regs.sv
module dbg_bp_regs
    import dbg_bp_pkg::*;
#(
    parameter int unsigned P_NUM_BP  = NUM_BP,
    parameter int unsigned P_BP_W    = BP_W,
    parameter int unsigned P_HADDR_W = HADDR_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              tlr,
    input  logic                              wr_en,
    input  logic [P_HADDR_W-1:0]              addr,
    input  logic [P_BP_W-1:0]                 wdata,
    output logic [P_BP_W-1:0]                 rdata,
    output logic [P_NUM_BP-1:0][P_BP_W-1:0]   bp_o,
    output logic [P_BP_W-1:0]                 mask_o,
    output logic [P_BP_W-1:0]                 cmp_o,
    output logic                              en_o,
    output logic                              mode_o
);
    hregs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            for (int k = 0; k < int'(P_NUM_BP); k++) begin
                if (addr == P_HADDR_W'(k)) r_d.bp[k] = wdata;
            end
            if (addr == P_HADDR_W'(HA_MASK)) r_d.mask = wdata;
            if (addr == P_HADDR_W'(HA_DATA)) r_d.cmp  = wdata;
            if (addr == P_HADDR_W'(HA_CTRL)) begin
                r_d.en   = wdata[0];
                r_d.mode = wdata[1];
            end
        end
        if (tlr) r_d.bp = '1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.bp   <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < int'(P_NUM_BP); k++) begin
            if (addr == P_HADDR_W'(k)) rdata = r_q.bp[k];
        end
        if (addr == P_HADDR_W'(HA_MASK)) rdata = r_q.mask;
        if (addr == P_HADDR_W'(HA_DATA)) rdata = r_q.cmp;
        if (addr == P_HADDR_W'(HA_CTRL)) rdata = {{(P_BP_W-2){1'b0}}, r_q.mode, r_q.en};
    end

    assign bp_o   = r_q.bp;
    assign mask_o = r_q.mask;
    assign cmp_o  = r_q.cmp;
    assign en_o   = r_q.en;
    assign mode_o = r_q.mode;

    // R1: a test-logic-reset leaves every breakpoint at all ones
    assert_tlr_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tlr |=> (r_q.bp == '1));
endmodule

// File: rtl/dbg_bp_match.sv
module dbg_bp_match
    import dbg_bp_pkg::*;
#(
    parameter int unsigned P_NUM_BP  = NUM_BP,
    parameter int unsigned P_NUM_IBP = NUM_IBP,
    parameter int unsigned P_BP_W    = BP_W,
    parameter int unsigned P_MOD_W   = MOD_W,
    parameter int unsigned P_IDX_W   = IDX_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [P_NUM_BP-1:0][P_BP_W-1:0]   bp,
    input  logic [P_BP_W-1:0]                 mask,
    input  logic [P_BP_W-1:0]                 cmp,
    input  logic                              en,
    input  logic                              mode,
    input  logic                              fetch_valid,
    input  logic [P_BP_W-1:0]                 fetch_addr,
    input  logic                              dmem_valid,
    input  logic [P_BP_W-1:0]                 dmem_addr,
    input  logic                              dst_valid,
    input  logic [P_MOD_W-1:0]                dst_module,
    input  logic [P_IDX_W-1:0]                dst_index,
    input  logic [P_BP_W-1:0]                 dst_wdata,
    output logic                              hit
);
    localparam int unsigned IDX_LO = P_MOD_W;
    localparam int unsigned IDX_HI = P_MOD_W + P_IDX_W - 1;

    logic [P_NUM_BP-1:0] per_bp;
    logic                value_ok;

    assign value_ok = (((dst_wdata ^ cmp) & mask) == '0);

    for (genvar g = 0; g < int'(P_NUM_BP); g++) begin : g_bp
        if (g < int'(P_NUM_IBP)) begin : g_ifetch
            assign per_bp[g] = fetch_valid && (fetch_addr == bp[g]);
        end else begin : g_dual
            logic reg_hit, addr_hit;
            assign addr_hit  = dmem_valid && (dmem_addr == bp[g]);
            assign reg_hit   = dst_valid && value_ok
                             && (bp[g][P_MOD_W-1:0] == dst_module)
                             && (bp[g][IDX_HI:IDX_LO] == dst_index);
            assign per_bp[g] = mode ? reg_hit : addr_hit;
        end
    end

    assign hit = en && (|per_bp);

    // R6: in register mode with no fetch and no destination write, nothing matches
    assert_regmode_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !fetch_valid && !dst_valid) |-> !hit);
    // R5: in address mode with no fetch and no data access, nothing matches
    assert_addrmode_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && !fetch_valid && !dmem_valid) |-> !hit);
endmodule

// File: rtl/dbg_brk_unit.sv
module dbg_brk_unit
    import dbg_bp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tlr,
    input  logic               host_wr_en,
    input  logic [HADDR_W-1:0] host_addr,
    input  logic [BP_W-1:0]    host_wdata,
    output logic [BP_W-1:0]    host_rdata,
    input  logic               host_break_cmd,
    input  logic               host_resume,
    input  logic               fetch_valid,
    input  logic [BP_W-1:0]    fetch_addr,
    input  logic               dmem_valid,
    input  logic [BP_W-1:0]    dmem_addr,
    input  logic               dst_valid,
    input  logic [MOD_W-1:0]   dst_module,
    input  logic [IDX_W-1:0]   dst_index,
    input  logic [BP_W-1:0]    dst_wdata,
    input  logic               insn_prefix,
    input  logic               insn_done,
    output logic               brk_req,
    output logic [1:0]         dbg_status
);
    logic [NUM_BP-1:0][BP_W-1:0] bp;
    logic [BP_W-1:0]             mask, cmp;
    logic                        en, mode, hit, fire;
    seq_t                        s_d, s_q;

    dbg_bp_regs u_regs (
        .clk(clk), .rst_n(rst_n), .tlr(tlr),
        .wr_en(host_wr_en), .addr(host_addr), .wdata(host_wdata), .rdata(host_rdata),
        .bp_o(bp), .mask_o(mask), .cmp_o(cmp), .en_o(en), .mode_o(mode)
    );

    dbg_bp_match u_match (
        .clk(clk), .rst_n(rst_n),
        .bp(bp), .mask(mask), .cmp(cmp), .en(en), .mode(mode),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .dmem_valid(dmem_valid), .dmem_addr(dmem_addr),
        .dst_valid(dst_valid), .dst_module(dst_module), .dst_index(dst_index),
        .dst_wdata(dst_wdata), .hit(hit)
    );

    always_comb begin
        s_d     = s_q;
        s_d.brk = 1'b0;
        fire    = 1'b0;
        if (s_q.st == ST_BACKGROUND) begin
            if (host_break_cmd)                              fire     = 1'b1;
            else if (hit && insn_prefix)                     s_d.pend = 1'b1;
            else if (hit)                                    fire     = 1'b1;
            else if (s_q.pend && insn_done && !insn_prefix)  fire     = 1'b1;
            if (fire) begin
                s_d.brk  = 1'b1;
                s_d.st   = ST_DEBUG_IDLE;
                s_d.pend = 1'b0;
            end
        end else begin
            s_d.pend = 1'b0;
            if (host_resume) s_d.st = ST_BACKGROUND;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{brk: 1'b0, st: ST_BACKGROUND, pend: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign brk_req    = s_q.brk;
    assign dbg_status = s_q.st;

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |=> !brk_req);
    assert_pulse_status_R9: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (dbg_status == 2'b01));
    assert_resume_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_status == 2'b01 && host_resume) |=> (dbg_status == 2'b00 && !brk_req));
    assert_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !host_break_cmd && !s_q.pend) |=> !brk_req);
    assert_defer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_status == 2'b00 && insn_prefix && !host_break_cmd) |=> !brk_req);
endmodule

// File: tb/tb_dbg_brk_unit.sv
`timescale 1ns/1ps
module tb_dbg_brk_unit;
    logic        clk = 1'b0, rst_n = 1'b0, tlr = 1'b0;
    logic        host_wr_en = 1'b0, host_break_cmd = 1'b0, host_resume = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0, host_rdata;
    logic        fetch_valid = 1'b0, dmem_valid = 1'b0, dst_valid = 1'b0;
    logic [15:0] fetch_addr = '0, dmem_addr = '0, dst_wdata = '0;
    logic [3:0]  dst_module = '0;
    logic [4:0]  dst_index = '0;
    logic        insn_prefix = 1'b0, insn_done = 1'b0;
    logic        brk_req;
    logic [1:0]  dbg_status;

    int total = 0, bad = 0;
    bit finished = 0;

    typedef struct {
        logic       brk;
        logic [1:0] st;
        string      tag;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;

    dbg_brk_unit dut (.*);

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compares each scoreboard item one step after the edge it belongs to
    always @(posedge clk) begin
        #1;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            check16({e.tag, " brk_req"}, {15'd0, brk_req}, {15'd0, e.brk});
            check16({e.tag, " dbg_status"}, {14'd0, dbg_status}, {14'd0, e.st});
        end
    end

    task automatic idle_in();
        fetch_valid = 0; dmem_valid = 0; dst_valid = 0;
        insn_prefix = 0; insn_done = 0; host_break_cmd = 0; host_resume = 0; tlr = 0;
    endtask

    // driver: push the expected outputs after this cycle's edge, then advance
    task automatic cyc(input logic b, input logic [1:0] s, input string tag);
        exp_t e;
        e.brk = b; e.st = s; e.tag = tag;
        q.push_back(e);
        @(negedge clk);
        idle_in();
    endtask

    task automatic hw(input logic [3:0] a, input logic [15:0] d);
        host_wr_en = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
        host_addr = a;
        #1;
        check16(tag, host_rdata, exp);
    endtask

    task automatic resume();
        host_resume = 1;
        cyc(0, 2'b00, "R10 resume");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check16("R1 brk_req after reset", {15'd0, brk_req}, 16'd0);
        check16("R1 status after reset", {14'd0, dbg_status}, 16'd0);
        for (int k = 0; k < 6; k++) rd(4'(k), 16'hFFFF, "R1 bp reset value");
        rd(4'd6, 16'h0000, "R1 mask reset");
        rd(4'd8, 16'h0000, "R1 ctrl reset");

        // R2 host write / read
        hw(4'd0, 16'h1234);
        rd(4'd0, 16'h1234, "R2 bp0 readback");
        hw(4'd7, 16'h5A5A);
        rd(4'd7, 16'h5A5A, "R2 data readback");

        // R3 disabled
        fetch_valid = 1; fetch_addr = 16'h1234;
        cyc(0, 2'b00, "R3 disabled no break");

        hw(4'd8, 16'h0001);
        rd(4'd8, 16'h0001, "R2 ctrl readback");

        // R4 fetch valid gating and full compare
        fetch_valid = 0; fetch_addr = 16'h1234;
        cyc(0, 2'b00, "R4 invalid fetch ignored");
        fetch_valid = 1; fetch_addr = 16'h1235;
        cyc(0, 2'b00, "R4 near address no break");
        fetch_valid = 1; fetch_addr = 16'h1234;
        cyc(1, 2'b01, "R9 break pulse");
        cyc(0, 2'b01, "R9 pulse is single");
        fetch_valid = 1; fetch_addr = 16'h1234;
        cyc(0, 2'b01, "R10 match ignored in debug");
        resume();

        hw(4'd3, 16'hA5A5);
        fetch_valid = 1; fetch_addr = 16'hA5A5;
        cyc(1, 2'b01, "R4 bp3 fetch match");
        resume();

        // R5 address mode for bp4/bp5
        hw(4'd4, 16'h0200);
        dmem_valid = 1; dmem_addr = 16'h0200;
        cyc(1, 2'b01, "R5 data address match");
        resume();
        dst_valid = 1; dst_module = 4'h0; dst_index = 5'h00; dst_wdata = 16'h0000;
        cyc(0, 2'b00, "R5 dst write ignored in address mode");

        // R6 register mode
        hw(4'd8, 16'h0003);
        dmem_valid = 1; dmem_addr = 16'h0200;
        cyc(0, 2'b00, "R6 data address ignored in register mode");
        hw(4'd5, 16'hFE57);
        dst_valid = 1; dst_module = 4'h7; dst_index = 5'h06; dst_wdata = 16'h0;
        cyc(0, 2'b00, "R6 wrong index no break");
        dst_valid = 1; dst_module = 4'h7; dst_index = 5'h05; dst_wdata = 16'hBEEF;
        cyc(1, 2'b01, "R6 R7 module/index match with zero mask");
        resume();

        // R7 masked value compare
        hw(4'd6, 16'h00F0);
        hw(4'd7, 16'h0030);
        dst_valid = 1; dst_module = 4'h7; dst_index = 5'h05; dst_wdata = 16'hAB4C;
        cyc(0, 2'b00, "R7 masked field differs");
        dst_valid = 1; dst_module = 4'h7; dst_index = 5'h05; dst_wdata = 16'hAB3C;
        cyc(1, 2'b01, "R7 masked field equal");
        resume();

        // R8 prefix deferral
        hw(4'd8, 16'h0001);
        fetch_valid = 1; fetch_addr = 16'h1234; insn_prefix = 1;
        cyc(0, 2'b00, "R8 held on prefix cycle");
        cyc(0, 2'b00, "R8 held until completion");
        insn_done = 1;
        cyc(1, 2'b01, "R8 break after prefixed op");
        resume();

        // R11 host forced entry while disabled
        hw(4'd8, 16'h0000);
        host_break_cmd = 1;
        cyc(1, 2'b01, "R11 host break command");
        resume();

        // R1 test-logic-reset
        tlr = 1;
        @(negedge clk);
        tlr = 0;
        rd(4'd0, 16'hFFFF, "R1 tlr reloads bp0");
        rd(4'd5, 16'hFFFF, "R1 tlr reloads bp5");

        repeat (3) @(negedge clk);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule